// File: doc/BRIEF.md
# Multi-Mode Configurable Logic Cell

This block is one programmable logic cell of the kind tiled across a reconfigurable fabric. It holds a static configuration word that sets a 16-bit truth-table mask and an operating mode. The same storage serves three modes. As a general logic cell it is one 4-input lookup table. As an arithmetic cell it is a pair of 3-input lookup tables, one for the sum and one for the carry. As a counter cell it is a one-bit counter slice with enable, direction, clear and load.

Every mode drives a combinational output and a registered output. Each mode also feeds a carry output and a cascade output, so that neighbouring cells can be chained into wide adders, wide counters or wide AND/OR decoders. The register is shared by all modes. Clock enable gates it. A synchronous clear and a synchronous load act on it in every mode.

Top module: `logic_cell`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, the register and the configuration are zero. With that configuration: combOut = 0, regOut = 0, cascadeOut = 0, carryOut = carryIn.
- R2: When cfgWe is high at a rising clock edge, cfgWord is captured and takes effect from that edge on. The fields of cfgWord are: bits [15:0] mask, bits [17:16] mode (0 logic, 1 arithmetic, 2 counter, 3 behaves as logic), bit 18 cascade operator (0 AND, 1 OR), bit 19 fourth-input select (1 carryIn, 0 dataIn[3]), bit 20 packed register.
- R3: In logic mode, combOut = mask[{x, dataIn[2], dataIn[1], dataIn[0]}], where x is carryIn if bit 19 is set and dataIn[3] otherwise.
- R4: In every mode, cascadeOut = combOut AND cascadeIn when bit 18 is 0, and combOut OR cascadeIn when bit 18 is 1.
- R5: In logic mode, carryOut equals carryIn.
- R6: In arithmetic mode, with i = {carryIn, dataIn[1], dataIn[0]}, combOut = mask[i] and carryOut = mask[8+i]. The mask 0xE896 forms a full adder.
- R7: When clkEn is high and neither clear nor load is asserted, regOut takes combOut at the edge. The exception is logic mode with bit 20 set: there the register takes dataIn[3] instead, independently of the table.
- R8: While clkEn is low, regOut holds its value whatever the other inputs do.
- R9: With clkEn high, syncClr forces regOut to 0 and takes priority over syncLoad and over counting.
- R10: With clkEn high and syncClr low, syncLoad loads dataIn[2] into the register and takes priority over counting or table update.
- R11: In counter mode, dataIn[0] is the count enable and dataIn[1] the direction (1 up). The bit toggles when dataIn[0] and carryIn are both 1. combOut shows the next count bit.
- R12: In counter mode, carryOut = dataIn[0] & carryIn & (regOut when counting up, not regOut when counting down). This is the carry or borrow passed to the next slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWord | input | 21 | Configuration word (mask, mode, cascade operator, fourth-input select, packed register) |
| dataIn | input | 4 | Data inputs |
| carryIn | input | 1 | Carry from the previous cell |
| cascadeIn | input | 1 | Cascade from the previous cell |
| clkEn | input | 1 | Register clock enable |
| syncClr | input | 1 | Synchronous clear |
| syncLoad | input | 1 | Synchronous load of dataIn[2] |
| combOut | output | 1 | Combinational result of the current mode |
| regOut | output | 1 | Registered output |
| carryOut | output | 1 | Carry or borrow to the next cell |
| cascadeOut | output | 1 | Cascade chain output |

## Verification
The hardest situation to reach from the ports is a counter borrow or carry that depends on a stored bit. This needs a register value that was set up earlier in the same mode, while carryIn and the enable are asserted and the direction is flipped. The stimulus first uses load and clear to place the bit at 0 or 1 directly. It then counts in both directions across the wrap. A long randomized stretch follows that rewrites the configuration in the middle of a run. That stretch covers mode changes that happen while the register holds a value from a different mode.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_K       = 4;
  localparam int MASK_W      = 1 << LUT_K;
  localparam int HALF_W      = MASK_W / 2;
  localparam int CFG_W       = MASK_W + 5;
  localparam int CNT_EN_BIT  = 0;
  localparam int CNT_DIR_BIT = 1;
  localparam int LOAD_BIT    = 2;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_COUNT = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;

  typedef struct packed {
    logic               pkdReg;
    logic               fourthCin;
    logic               cascOr;
    mode_e              mode;
    logic [MASK_W-1:0]  mask;
  } cfg_t;

  typedef struct packed {
    logic arithMode;
    logic countMode;
    logic fourthCin;
    logic cascOr;
    logic pkdReg;
    logic regClear;
    logic regLoad;
    logic regWrite;
  } strobe_t;
endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              clkEn,
  input  logic              syncClr,
  input  logic              syncLoad,
  output strobe_t           strobe,
  output logic [MASK_W-1:0] lutMask
);
  cfg_t cfgQ;
  logic isArith;
  logic isCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfg_t'(cfgWord);
  end

  assign isArith = (cfgQ.mode == MODE_ARITH);
  assign isCount = (cfgQ.mode == MODE_COUNT);

  always_comb begin
    strobe           = '0;
    strobe.arithMode = isArith;
    strobe.countMode = isCount;
    strobe.fourthCin = cfgQ.fourthCin & ~isArith & ~isCount;
    strobe.cascOr    = cfgQ.cascOr;
    strobe.pkdReg    = cfgQ.pkdReg & ~isArith & ~isCount;
    strobe.regClear  = clkEn & syncClr;
    strobe.regLoad   = clkEn & ~syncClr & syncLoad;
    strobe.regWrite  = clkEn & ~syncClr & ~syncLoad;
  end

  assign lutMask = cfgQ.mask;
endmodule

// File: rtl/lcell_dp.sv
module lcell_dp
  import lcell_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [MASK_W-1:0] lutMask,
  input  logic [LUT_K-1:0]  dataIn,
  input  logic              carryIn,
  input  logic              cascadeIn,
  output logic              combOut,
  output logic              regOut,
  output logic              carryOut,
  output logic              cascadeOut
);
  logic             fourthIn;
  logic [LUT_K-1:0] normIdx;
  logic             normOut;
  logic [LUT_K-2:0] arithIdx;
  logic [1:0]       halfOut;
  logic             regQ;
  logic             regD;
  logic             cntToggle;
  logic             cntNext;
  logic             cntCarry;

  // logic mode: one table over four inputs, the top one selectable
  assign fourthIn = strobe.fourthCin ? carryIn : dataIn[LUT_K-1];
  assign normIdx  = {fourthIn, dataIn[LUT_K-2:0]};
  assign normOut  = lutMask[normIdx];

  // arithmetic mode: the mask splits into two half tables sharing one index
  assign arithIdx = {carryIn, dataIn[LUT_K-3:0]};
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] halfMask;
    assign halfMask   = lutMask[h*HALF_W +: HALF_W];
    assign halfOut[h] = halfMask[arithIdx];
  end

  // counter mode: one-bit slice of a ripple counter
  assign cntToggle = dataIn[CNT_EN_BIT] & carryIn;
  assign cntNext   = regQ ^ cntToggle;
  assign cntCarry  = cntToggle & (dataIn[CNT_DIR_BIT] ? regQ : ~regQ);

  always_comb begin
    if (strobe.countMode) begin
      combOut  = cntNext;
      carryOut = cntCarry;
    end else if (strobe.arithMode) begin
      combOut  = halfOut[0];
      carryOut = halfOut[1];
    end else begin
      combOut  = normOut;
      carryOut = carryIn;
    end
  end

  assign cascadeOut = strobe.cascOr ? (combOut | cascadeIn) : (combOut & cascadeIn);

  always_comb begin
    regD = regQ;
    if (strobe.regClear)      regD = 1'b0;
    else if (strobe.regLoad)  regD = dataIn[LOAD_BIT];
    else if (strobe.regWrite) regD = strobe.pkdReg ? dataIn[LUT_K-1] : combOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= 1'b0;
    else regQ <= regD;
  end

  assign regOut = regQ;
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [LUT_K-1:0] dataIn,
  input  logic             carryIn,
  input  logic             cascadeIn,
  input  logic             clkEn,
  input  logic             syncClr,
  input  logic             syncLoad,
  output logic             combOut,
  output logic             regOut,
  output logic             carryOut,
  output logic             cascadeOut
);
  strobe_t           strobe;
  logic [MASK_W-1:0] lutMask;

  lcell_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .clkEn(clkEn), .syncClr(syncClr), .syncLoad(syncLoad),
    .strobe(strobe), .lutMask(lutMask)
  );

  lcell_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lutMask(lutMask),
    .dataIn(dataIn), .carryIn(carryIn), .cascadeIn(cascadeIn),
    .combOut(combOut), .regOut(regOut), .carryOut(carryOut),
    .cascadeOut(cascadeOut)
  );
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [2:0] cfgBits,
  input logic [2:0] dataLo,
  input logic       carryIn,
  input logic       cascadeIn,
  input logic       clkEn,
  input logic       syncClr,
  input logic       syncLoad,
  input logic       regOut,
  input logic       carryOut,
  input logic       cascadeOut
);
  logic [1:0] modeQ;
  logic       orQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 2'b00;
      orQ   <= 1'b0;
    end else if (cfgWe) begin
      modeQ <= cfgBits[1:0];
      orQ   <= cfgBits[2];
    end
  end

  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(regOut)) else $error("hold"); // R8
  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && syncClr) |=> !regOut) else $error("clear"); // R9
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !syncClr && syncLoad) |=> (regOut == $past(dataLo[2]))) else $error("load"); // R10
  AST_CASC_AND_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!orQ && !cascadeIn) |-> !cascadeOut) else $error("cascade and"); // R4
  AST_CASC_OR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (orQ && cascadeIn) |-> cascadeOut) else $error("cascade or"); // R4
  AST_LOGIC_CARRY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b00 || modeQ == 2'b11) |-> (carryOut == carryIn)) else $error("carry pass"); // R5
  AST_COUNT_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b10 && !(carryIn && dataLo[0])) |-> !carryOut) else $error("count carry"); // R12
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b10 && !cfgWe && clkEn && !syncClr && !syncLoad && !(dataLo[0] && carryIn))
      |=> $stable(regOut)) else $error("count idle"); // R11
endmodule

bind logic_cell lcell_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBits(cfgWord[18:16]),
  .dataLo(dataIn[2:0]), .carryIn(carryIn), .cascadeIn(cascadeIn),
  .clkEn(clkEn), .syncClr(syncClr), .syncLoad(syncLoad),
  .regOut(regOut), .carryOut(carryOut), .cascadeOut(cascadeOut)
);

// File: tb/tb_logic_cell.sv
`timescale 1ns/1ps
module tb_logic_cell;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [20:0] cfgWord = '0;
  logic [3:0]  dataIn = '0;
  logic        carryIn = 1'b0, cascadeIn = 1'b0, clkEn = 1'b0, syncClr = 1'b0, syncLoad = 1'b0;
  logic        combOut, regOut, carryOut, cascadeOut;

  int    nChecks = 0;
  int    nErr = 0;
  string curReq = "R1";

  // reference state
  int mMask = 0, mMode = 0, mOr = 0, mFourth = 0, mPkd = 0, mQ = 0;

  always #2.5 clk = ~clk;

  logic_cell dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord), .dataIn(dataIn),
    .carryIn(carryIn), .cascadeIn(cascadeIn), .clkEn(clkEn), .syncClr(syncClr),
    .syncLoad(syncLoad), .combOut(combOut), .regOut(regOut), .carryOut(carryOut),
    .cascadeOut(cascadeOut)
  );

  function automatic logic [20:0] mk(input int mask, input int mode, input int useOr,
                                     input int fourth, input int pkd);
    logic [20:0] w;
    w[15:0]  = mask[15:0];
    w[17:16] = mode[1:0];
    w[18]    = useOr[0];
    w[19]    = fourth[0];
    w[20]    = pkd[0];
    return w;
  endfunction

  function automatic int bitOf(input int v, input int pos);
    return (v >> pos) & 1;
  endfunction

  task automatic modelOut(output int c, output int cy, output int co);
    int d0, d1, d2, d3, ci, idx, t;
    d0 = dataIn[0]; d1 = dataIn[1]; d2 = dataIn[2]; d3 = dataIn[3]; ci = carryIn;
    if (mMode == 1) begin
      idx = d0 + 2*d1 + 4*ci;
      c   = bitOf(mMask, idx);
      cy  = bitOf(mMask, 8 + idx);
    end else if (mMode == 2) begin
      t  = d0 & ci;
      c  = (mQ + t) % 2;
      cy = t * ((d1 == 1) ? mQ : 1 - mQ);
    end else begin
      idx = d0 + 2*d1 + 4*d2 + 8*((mFourth == 1) ? ci : d3);
      c   = bitOf(mMask, idx);
      cy  = ci;
    end
    if (mOr == 1) co = (c + int'(cascadeIn) > 0) ? 1 : 0;
    else          co = c * int'(cascadeIn);
  endtask

  task automatic chk(input string what, input logic act, input int exp);
    nChecks++;
    if (act !== exp[0]) begin
      nErr++;
      $display("FAIL %s %s actual=%b expected=%0d", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int c, cy, co;
    modelOut(c, cy, co);
    chk("combOut", combOut, c);
    chk("regOut", regOut, mQ);
    chk("carryOut", carryOut, cy);
    chk("cascadeOut", cascadeOut, co);
  endtask

  // called one time unit after a rising edge
  task automatic tick(input logic [3:0] d, input logic ci, input logic cs, input logic ce,
                      input logic cl, input logic ld, input logic we, input logic [20:0] w);
    int c, cy, co;
    dataIn = d; carryIn = ci; cascadeIn = cs; clkEn = ce; syncClr = cl; syncLoad = ld;
    cfgWe = we; cfgWord = w;
    #1;
    compareAll();
    modelOut(c, cy, co);
    @(posedge clk);
    if (ce) begin
      if (cl) mQ = 0;
      else if (ld) mQ = d[2];
      else if (mMode != 1 && mMode != 2 && mPkd == 1) mQ = d[3];
      else mQ = c;
    end
    if (we) begin
      mMask = w[15:0]; mMode = w[17:16]; mOr = w[18]; mFourth = w[19]; mPkd = w[20];
    end
    #1;
  endtask

  task automatic cfg(input logic [20:0] w);
    tick(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, w);
  endtask

  initial begin
    #1_000_000;
    nErr++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    @(posedge clk); #1;
    carryIn = 1'b1; cascadeIn = 1'b1; dataIn = 4'hF;
    #1;
    compareAll();
    @(posedge clk); #1;
    rstN = 1'b1;
    tick(4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    // R2 R3: 4-input AND, fourth input from dataIn[3]
    curReq = "R2";
    cfg(mk(16'h8000, 0, 0, 0, 0));
    curReq = "R3";
    for (int i = 0; i < 16; i++) tick(i[3:0], 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // R3: fourth input from carryIn, dataIn[3] held opposite
    cfg(mk(16'h8000, 0, 0, 1, 0));
    for (int i = 0; i < 16; i++) tick({~i[3], i[2:0]}, i[3], 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // R3: mode 3 behaves as logic mode (parity)
    cfg(mk(16'h6996, 3, 0, 0, 0));
    for (int i = 0; i < 16; i++) tick(i[3:0], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R4 R5: OR cascade and carry pass-through
    curReq = "R4";
    cfg(mk(16'h0001, 0, 1, 0, 0));
    for (int i = 0; i < 8; i++) tick({1'b0, i[2], 2'b00}, i[1], i[0], 1'b0, 1'b0, 1'b0, 1'b0, '0);
    curReq = "R5";
    for (int i = 0; i < 4; i++) tick(4'h3, i[0], i[1], 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R6 R7: full adder, registered sum
    curReq = "R6";
    cfg(mk(16'hE896, 1, 0, 0, 0));
    for (int i = 0; i < 8; i++) tick({2'b00, i[1:0]}, i[2], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    curReq = "R7";
    for (int i = 0; i < 8; i++) tick({2'b11, i[1:0]}, i[2], 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    // R7: packed register follows dataIn[3], table is all zeros
    cfg(mk(16'h0000, 0, 1, 0, 1));
    for (int i = 0; i < 6; i++) tick({i[0], 3'b000}, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    // R8: no clock enable, everything else wiggles
    curReq = "R8";
    cfg(mk(16'hFFFF, 0, 0, 0, 0));
    tick(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 8; i++) tick(4'h0, i[0], 1'b1, 1'b0, i[1], i[2], 1'b0, '0);

    // R9 R10: clear and load priority
    curReq = "R9";
    tick(4'h4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    tick(4'h4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    curReq = "R10";
    cfg(mk(16'hFFFF, 0, 0, 0, 0));
    tick(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    tick(4'h4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    tick(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R11 R12: counter up and down through the wrap
    curReq = "R11";
    cfg(mk(16'h0000, 2, 0, 0, 0));
    tick(4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < 6; i++) tick(4'b0011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    curReq = "R12";
    for (int i = 0; i < 6; i++) tick(4'b0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    tick(4'b0100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < 8; i++) tick({2'b00, i[1], 1'b1}, i[0], 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    curReq = "R11";
    for (int i = 0; i < 4; i++) tick({2'b00, i[0], 1'b0}, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    // mixed random run with configuration rewrites
    curReq = "R3 R6 R11";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [31:0] m;
      r = $urandom;
      m = $urandom;
      tick(r[3:0], r[4], r[5], r[6], (r[9:7] == 3'd0), (r[12:10] == 3'd0),
           (r[15:13] == 3'd0), mk(int'(m[15:0]), int'(m[17:16]), int'(m[18]),
           int'(m[19]), int'(m[20])));
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule